// File: doc/BRIEF.md
# Two-Dimensional 8x8 DCT with Shared 1-D Engine

This block computes the orthonormal two-dimensional discrete cosine transform of an 8x8 tile of signed pixels. It relies on separability. Each row of eight pixels is transformed by a single 8-point 1-D transform engine. The row results go into a 64-entry transpose store, one row per write. Once all eight rows are held, the same engine is reused for the column pass. It reads one column of the store per step, and each column result is serialised onto the output port.

Pixels arrive in raster order under a valid/ready handshake. The input side contains a serial-to-parallel stage that gathers eight pixels into one engine operand. Because only one engine exists, the block drops its ready signal while the column pass runs. The row results are held unrounded, and rounding to the output width takes place once, after the column pass. Coefficients leave one per cycle with a valid flag. A start flag marks the first coefficient of each tile.

Top module: `dct2d_top`

## Requirements
- R1: While reset is held and immediately after it is released, in_ready is 1, out_valid is 0 and out_start is 0.
- R2: A pixel is taken on a rising edge where in_valid and in_ready are both 1. Pixels of a tile are taken in raster order, so pixel number y*8+x is row y, column x. Cycles with in_valid at 0 take nothing, whatever in_pixel holds.
- R3: in_ready is 0 from the edge that takes the 64th pixel of a tile until out_valid falls. Data offered during that time is not taken and does not change the results.
- R4: A tile yields exactly 64 coefficients on consecutive cycles. Output number i (0..63) carries F(v,u) with horizontal frequency u = i/8 and vertical frequency v = i%8.
- R5: out_start is 1 for exactly one cycle per tile, together with output number 0, and is 0 at all other times.
- R6: Each coefficient is within 1 of F(v,u) = c(u)c(v)/4 * sum over y,x of p(y,x)*cos((2x+1)u*pi/16)*cos((2y+1)v*pi/16), where c(0)=1/sqrt(2) and c(k)=1 otherwise. This holds for pixels in -128..127.
- R7: out_valid first becomes 1 on the second rising edge after the edge that takes the 64th pixel.
- R8: in_ready returns to 1 on the same edge on which out_valid falls after output number 63. A tile sent immediately afterwards is transformed with no influence from the previous tile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_pixel holds a pixel |
| in_pixel | input | IN_W (8) | Signed pixel, two's complement |
| in_ready | output | 1 | Block can take a pixel this cycle |
| out_valid | output | 1 | out_coef holds a coefficient |
| out_start | output | 1 | Marks coefficient (0,0) of a tile |
| out_coef | output | OUT_W (12) | Signed rounded coefficient |

## Verification
The tiles are chosen so that different faults show up in different places:
- A flat tile puts all energy into the DC term, so any leak into other positions shows up at once.
- A horizontal ramp fills only u-indexed terms with v=0, which exposes a swapped output order or a transpose that fails to turn rows into columns.
- A checkerboard at full swing drives the highest frequency in both directions at the largest sums, testing width and sign handling. It is sent with junk offered while the block is busy.
- A tile of all -128 reaches the most negative DC value of -1024.
- A pseudo-random tile exercises every weight. Its expected values can be met only if the row results are stored unrounded, and it is sent back-to-back to catch residue left from the previous tile.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // points per 1-D transform and tile edge length
  localparam int PTS = 8;
  // fractional bits of one weight: row results carry WF, column sums 2*WF
  localparam int WF = 15;
  localparam int W_W = 16;

  // cos(m*pi/16) scaled by 2^14, m = 0..8
  function automatic int cos_q14(input int m);
    case (m)
      0: return 16384;
      1: return 16069;
      2: return 15137;
      3: return 13623;
      4: return 11585;
      5: return 9102;
      6: return 6270;
      7: return 3196;
      default: return 0;
    endcase
  endfunction

  // weight for output frequency k and input sample n, scaled by 2^WF:
  // c(k)/2 * cos((2n+1)k*pi/16); for k>0 this equals cos scaled by 2^14
  function automatic logic signed [W_W-1:0] dct_weight(input int k, input int n);
    int m;
    int c;
    if (k == 0) return W_W'(11585);
    m = ((2 * n + 1) * k) % 32;
    if (m <= 8)       c = cos_q14(m);
    else if (m <= 16) c = -cos_q14(16 - m);
    else if (m <= 24) c = -cos_q14(m - 16);
    else              c = cos_q14(32 - m);
    return W_W'(c);
  endfunction

endpackage

// File: rtl/dct_s2p.sv
module dct_s2p
  import dct_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int ACC_W = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic signed [IN_W-1:0]  px,
  output logic signed [ACC_W-1:0] vec [PTS],
  output logic                    grp_done
);
  localparam int CW = $clog2(PTS);
  localparam logic [CW-1:0] LAST = CW'(PTS - 1);

  logic [CW-1:0]          cnt;
  logic signed [IN_W-1:0] hold [PTS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      grp_done <= 1'b0;
      for (int i = 0; i < PTS - 1; i++) hold[i] <= '0;
      for (int i = 0; i < PTS; i++) vec[i] <= '0;
    end else begin
      grp_done <= push && (cnt == LAST);
      if (push) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          for (int i = 0; i < PTS - 1; i++) vec[i] <= ACC_W'(hold[i]);
          vec[PTS-1] <= ACC_W'(px);
        end else begin
          hold[cnt] <= px;
        end
      end
    end
  end

  // R2: a completed group always follows an accepted pixel
  a_r2_group_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |-> $past(push));

endmodule

// File: rtl/dct_engine.sv
module dct_engine
  import dct_pkg::*;
#(
  parameter int ACC_W = 27,
  parameter int SUM_W = 46
) (
  input  logic signed [ACC_W-1:0] vin  [PTS],
  output logic signed [SUM_W-1:0] vout [PTS]
);
  // one dot product per output frequency
  for (genvar k = 0; k < PTS; k++) begin : g_freq
    always_comb begin
      logic signed [SUM_W-1:0] acc;
      acc = '0;
      for (int n = 0; n < PTS; n++)
        acc = acc + SUM_W'(vin[n]) * SUM_W'(dct_weight(k, n));
      vout[k] = acc;
    end
  end

endmodule

// File: rtl/dct_tbuf.sv
module dct_tbuf
  import dct_pkg::*;
#(
  parameter int ACC_W = 27
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [$clog2(PTS)-1:0]     wr_row,
  input  logic signed [ACC_W-1:0]    wr_vec [PTS],
  input  logic [$clog2(PTS)-1:0]     rd_col,
  output logic signed [ACC_W-1:0]    rd_vec [PTS]
);
  logic signed [ACC_W-1:0] mem [PTS][PTS];

  // written one row at a time
  always_ff @(posedge clk) begin
    if (wr_en)
      for (int c = 0; c < PTS; c++) mem[wr_row][c] <= wr_vec[c];
  end

  // read one column at a time
  always_comb begin
    for (int r = 0; r < PTS; r++) rd_vec[r] = mem[r][rd_col];
  end

endmodule

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   grp_done,
  output logic                   in_ready,
  output logic                   accept,
  output logic [$clog2(PTS)-1:0] wr_row,
  output logic [$clog2(PTS)-1:0] col,
  output logic [$clog2(PTS)-1:0] vi,
  output logic                   col_phase
);
  localparam int CW    = $clog2(PTS);
  localparam int BLK   = PTS * PTS;
  localparam int BW    = $clog2(BLK);
  localparam logic [CW-1:0] LAST    = CW'(PTS - 1);
  localparam logic [BW-1:0] LAST_PX = BW'(BLK - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_COL, ST_DONE} phase_e;

  phase_e         state;
  logic [BW-1:0]  acc_cnt;
  logic           all_in;

  assign in_ready  = ((state == ST_IDLE) || (state == ST_ROW)) && !all_in;
  assign accept    = in_valid && in_ready;
  assign col_phase = (state == ST_COL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      acc_cnt <= '0;
      all_in  <= 1'b0;
      wr_row  <= '0;
      col     <= '0;
      vi      <= '0;
    end else begin
      if (accept) begin
        acc_cnt <= acc_cnt + 1'b1;
        if (acc_cnt == LAST_PX) all_in <= 1'b1;
      end
      case (state)
        ST_IDLE: if (accept) state <= ST_ROW;
        ST_ROW: begin
          if (grp_done) begin
            wr_row <= wr_row + 1'b1;
            if (wr_row == LAST) state <= ST_COL;
          end
        end
        ST_COL: begin
          vi <= vi + 1'b1;
          if (vi == LAST) begin
            col <= col + 1'b1;
            if (col == LAST) state <= ST_DONE;
          end
        end
        default: begin
          state  <= ST_IDLE;
          all_in <= 1'b0;
        end
      endcase
    end
  end

  // R2: row groups complete only while rows are being gathered
  a_r2_group_in_row: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |-> (state == ST_ROW));

  // R3: once a whole tile is in, nothing more is taken
  a_r3_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    all_in |-> !accept);

  // R4: the column pass starts on its first coefficient
  a_r4_col_starts_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_phase) |-> (col == '0 && vi == '0));

endmodule

// File: rtl/dct2d_top.sv
module dct2d_top
  import dct_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_pixel,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic                    out_start,
  output logic signed [OUT_W-1:0] out_coef
);
  localparam int CW    = $clog2(PTS);
  localparam int ACC_W = IN_W + W_W + 3;
  localparam int SUM_W = ACC_W + W_W + 3;
  localparam logic signed [SUM_W-1:0] RND_BIAS = SUM_W'(1) <<< (2 * WF - 1);

  // column sums carry 2*WF fractional bits; round half up once
  function automatic logic signed [OUT_W-1:0] round_coef(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] t;
    t = (s + RND_BIAS) >>> (2 * WF);
    return OUT_W'(t);
  endfunction

  logic                    accept;
  logic                    grp_done;
  logic                    col_phase;
  logic [CW-1:0]           wr_row;
  logic [CW-1:0]           col;
  logic [CW-1:0]           vi;
  logic signed [ACC_W-1:0] row_vec  [PTS];
  logic signed [ACC_W-1:0] col_vec  [PTS];
  logic signed [ACC_W-1:0] eng_in   [PTS];
  logic signed [SUM_W-1:0] eng_out  [PTS];
  logic signed [ACC_W-1:0] row_res  [PTS];

  dct_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .grp_done  (grp_done),
    .in_ready  (in_ready),
    .accept    (accept),
    .wr_row    (wr_row),
    .col       (col),
    .vi        (vi),
    .col_phase (col_phase)
  );

  dct_s2p #(.IN_W(IN_W), .ACC_W(ACC_W)) u_s2p (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .px       (in_pixel),
    .vec      (row_vec),
    .grp_done (grp_done)
  );

  // the single engine: rows from the gatherer, columns from the store
  always_comb begin
    for (int i = 0; i < PTS; i++) eng_in[i] = col_phase ? col_vec[i] : row_vec[i];
  end

  dct_engine #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_eng (
    .vin  (eng_in),
    .vout (eng_out)
  );

  // row results stored at full precision (WF fractional bits kept)
  always_comb begin
    for (int i = 0; i < PTS; i++) row_res[i] = eng_out[i][ACC_W-1:0];
  end

  dct_tbuf #(.ACC_W(ACC_W)) u_tbuf (
    .clk    (clk),
    .wr_en  (grp_done),
    .wr_row (wr_row),
    .wr_vec (row_res),
    .rd_col (col),
    .rd_vec (col_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_coef  <= '0;
    end else begin
      out_valid <= col_phase;
      out_start <= col_phase && (col == '0) && (vi == '0);
      if (col_phase) out_coef <= round_coef(eng_out[vi]);
    end
  end

  // R3: no pixel is taken while coefficients stream out
  a_r3_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R5: the start flag only rides on a valid coefficient
  a_r5_start_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);

  // R5: the start flag lasts one cycle
  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |=> !out_start);

  // R5: every output burst opens with the start flag
  a_r5_burst_opens_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_start);

  // R8: the input reopens as the burst ends
  a_r8_ready_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> in_ready);

endmodule

// File: tb/sim_dct2d_top.sv
module sim_dct2d_top;
  localparam int CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [7:0] in_pixel = '0;
  logic              in_ready;
  logic              out_valid;
  logic              out_start;
  logic signed [11:0] out_coef;

  int checks = 0;
  int failures = 0;
  int img [64];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dct2d_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_pixel  (in_pixel),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_start (out_start),
    .out_coef  (out_coef)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // orthonormal 2-D DCT at vertical frequency v, horizontal frequency u
  function automatic real ref_coef(input int v, input int u);
    real s, cu, cv;
    s = 0.0;
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++)
        s += img[y*8+x] * $cos((2*x+1)*u*PI/16.0) * $cos((2*y+1)*v*PI/16.0);
    cu = (u == 0) ? $sqrt(0.5) : 1.0;
    cv = (v == 0) ? $sqrt(0.5) : 1.0;
    return 0.25 * cu * cv * s;
  endfunction

  task automatic send_px(input int v);
    bit rdy;
    in_valid = 1'b1;
    in_pixel = 8'(v);
    forever begin
      rdy = in_ready;
      @(posedge clk);
      @(negedge clk);
      if (rdy) break;
    end
  endtask

  task automatic idle_cycle(input int junk);
    in_valid = 1'b0;
    in_pixel = 8'(junk);
    @(posedge clk);
    @(negedge clk);
  endtask

  // send img, then check latency, order, values, flags and reopening
  task automatic run_tile(input bit gaps, input bit junk_busy, input string tag);
    int lat;
    real f, d;
    for (int p = 0; p < 64; p++) begin
      send_px(img[p]);
      if (gaps && (p % 3 == 1) && p != 63) idle_cycle(7 * p - 99);  // R2 gap with junk
    end
    in_valid = junk_busy;
    in_pixel = 8'sh55;
    chk(in_ready == 1'b0, {"R3 ready low after 64th ", tag}, in_ready, 0);
    lat = 1;
    while (!out_valid && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 3, {"R7 latency ", tag}, lat, 3);
    for (int i = 0; i < 64; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 63) in_valid = 1'b0;
      f = ref_coef(i % 8, i / 8);
      d = out_coef - f;
      chk(out_valid == 1'b1, {"R4 valid run ", tag}, out_valid, 1);
      chk(out_start == (i == 0), {"R5 start flag ", tag}, out_start, int'(i == 0));
      chk(d <= 1.0 && d >= -1.0, {"R6 coefficient ", tag}, out_coef, $rtoi(f));
      chk(in_ready == 1'b0, {"R3 ready while busy ", tag}, in_ready, 0);
    end
    @(negedge clk);
    chk(out_valid == 1'b0, {"R4 burst length ", tag}, out_valid, 0);
    chk(in_ready == 1'b1, {"R8 ready reopens ", tag}, in_ready, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    chk(out_start == 1'b0, "R1 start in reset", out_start, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after release", out_valid, 0);
  endtask

  task automatic t_flat();
    for (int p = 0; p < 64; p++) img[p] = 100;
    run_tile(1'b0, 1'b0, "flat");
  endtask

  task automatic t_ramp_gaps();
    for (int p = 0; p < 64; p++) img[p] = (p % 8) * 30 - 110;
    run_tile(1'b1, 1'b0, "ramp");
  endtask

  task automatic t_checker_busy();
    for (int p = 0; p < 64; p++) img[p] = (((p / 8) + (p % 8)) % 2 == 0) ? 127 : -128;
    run_tile(1'b0, 1'b1, "checker");
  endtask

  task automatic t_min();
    for (int p = 0; p < 64; p++) img[p] = -128;
    run_tile(1'b0, 1'b0, "min");
  endtask

  task automatic t_random_b2b();
    int seed = 12345;
    for (int p = 0; p < 64; p++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      img[p] = ((seed >> 16) % 256) - 128;
    end
    run_tile(1'b0, 1'b0, "random R8 back-to-back");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_flat();
    t_ramp_gaps();
    t_checker_busy();
    t_min();
    t_random_b2b();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule